// File: doc/BRIEF.md
# Circular scratch buffer address generator

This block produces the byte address of each sample access into a scratch buffer during one transfer. A load strobe captures a transfer descriptor: whether the target is a scratch buffer, whether circular addressing and offset write-back are requested, the starting offset, the buffer base, and the buffer size written as size minus one. Each advance strobe then moves the address on by one element of 1, 2 or 4 bytes.

In circular mode the address wraps back into the buffer when it reaches the buffer end (base plus programmed size plus one), and any overshoot is kept. A start offset at or past the end turns wrapping off for that transfer. A start offset below the base is raised to the base. When the last advance of a transfer is flagged and write-back is in effect, the block presents the final offset for one cycle so that it can be stored back into the descriptor. Memory access is not part of this block.

Top module: `scb_addr_gen`

## Requirements
- R1: After reset, `addr_o` is 0 and `fin_vld_o` is 0.
- R2: A load with `scratch_i`=1 and `circ_i`=1 and `base_i` <= `ofs_i` < `base_i`+`size_m1_i`+1 starts at `addr_o` = `ofs_i` with wrapping on.
- R3: A load with `scratch_i`=1, `circ_i`=1 and `ofs_i` < `base_i` starts at `addr_o` = `base_i` with wrapping on.
- R4: A load with `scratch_i`=1, `circ_i`=1 and `ofs_i` >= `base_i`+`size_m1_i`+1 starts at `ofs_i` and never wraps during that transfer.
- R5: Each cycle with `adv_i`=1 adds the element size to `addr_o`; `esz_i` 0 means 1 byte, 1 means 2 bytes, 2 and 3 mean 4 bytes. Without `adv_i` the address holds.
- R6: With wrapping on, a next address at or above the buffer end has `size_m1_i`+1 subtracted, keeping the overshoot (the programmed size must be at least the element size).
- R7: With `scratch_i`=0, offset, base and size have no effect: the transfer starts at address 0, runs linearly and never reports a final offset.
- R8: With `scratch_i`=1 and `circ_i`=0, the transfer starts at `ofs_i` and runs linearly with no wrap.
- R9: An advance with `last_i`=1 on a scratch transfer loaded with `wb_i`=1 raises `fin_vld_o` for exactly one cycle with `fin_ofs_o` equal to the address after that advance; if `wb_i` was 0, `fin_vld_o` stays 0.
- R10: A load in the same cycle as an advance takes priority: the advance is dropped.
- R11: The buffer end is computed one bit wider than the address, so a buffer reaching the top of the address space wraps correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_i | input | 1 | Load descriptor and start transfer |
| scratch_i | input | 1 | Target is a scratch buffer |
| circ_i | input | 1 | Circular addressing requested |
| wb_i | input | 1 | Final-offset write-back requested |
| ofs_i | input | ADDR_W | Start offset (byte address) |
| base_i | input | ADDR_W | Buffer base address |
| size_m1_i | input | ADDR_W | Buffer size minus one |
| esz_i | input | 2 | Element size code |
| adv_i | input | 1 | Advance by one element |
| last_i | input | 1 | Marks the final advance of the transfer |
| addr_o | output | ADDR_W | Current sample address |
| fin_ofs_o | output | ADDR_W | Final offset for write-back |
| fin_vld_o | output | 1 | Final offset valid (one cycle) |

## Verification
The bench builds the block with ADDR_W set to 16 instead of the default 32. That narrow width puts the top of the address space within a few small constants, so a buffer ending exactly at 0x10000 exercises the extra carry bit of the end computation. The other cases use buffers of a few hundred bytes so that wrap, overshoot, clamp and linear fall-back all occur within a handful of advances.

// File: rtl/scb_pkg.sv
package scb_pkg;
    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'd0,
        ESZ_HALF  = 2'd1,
        ESZ_WORD  = 2'd2,
        ESZ_WORDX = 2'd3
    } esz_e;

    function automatic logic [2:0] step_bytes(input logic [1:0] code);
        case (code)
            ESZ_BYTE: step_bytes = 3'd1;
            ESZ_HALF: step_bytes = 3'd2;
            default:  step_bytes = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/scb_start_sel.sv
module scb_start_sel #(
    parameter int ADDR_W = 32
) (
    input  logic              scratch_i,
    input  logic              circ_i,
    input  logic [ADDR_W-1:0] ofs_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] size_m1_i,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W:0]   end_o,
    output logic [ADDR_W:0]   span_o,
    output logic              wrap_o
);
    localparam int EW = ADDR_W + 1;

    always_comb begin
        span_o  = {1'b0, size_m1_i} + EW'(1);
        end_o   = {1'b0, base_i} + span_o;
        start_o = '0;
        wrap_o  = 1'b0;
        if (scratch_i) begin
            start_o = ofs_i;
            if (circ_i && ({1'b0, ofs_i} < end_o)) begin
                wrap_o = 1'b1;
                if (ofs_i < base_i) begin
                    start_o = base_i;
                end
            end
        end
    end
endmodule

// File: rtl/scb_stepper.sv
module scb_stepper #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        step_i,
    input  logic              wrap_i,
    input  logic [ADDR_W:0]   end_i,
    input  logic [ADDR_W:0]   span_i,
    output logic [ADDR_W-1:0] nxt_o
);
    localparam int EW = ADDR_W + 1;
    logic [ADDR_W:0] sum;

    always_comb begin
        sum = {1'b0, addr_i} + EW'(step_i);
        if (wrap_i && (sum >= end_i)) begin
            sum = sum - span_i;
        end
        nxt_o = sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/scb_addr_gen.sv
module scb_addr_gen
    import scb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic              scratch_i,
    input  logic              circ_i,
    input  logic              wb_i,
    input  logic [ADDR_W-1:0] ofs_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] size_m1_i,
    input  logic [1:0]        esz_i,
    input  logic              adv_i,
    input  logic              last_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] fin_ofs_o,
    output logic              fin_vld_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W:0]   end_a;
        logic [ADDR_W:0]   span;
        logic              wrap;
        logic              wb;
        logic [ADDR_W-1:0] fin_ofs;
        logic              fin_vld;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0] start_w;
    logic [ADDR_W:0]   end_w;
    logic [ADDR_W:0]   span_w;
    logic              wrap_w;
    logic [ADDR_W-1:0] nxt_w;
    logic [2:0]        step_w;

    assign step_w = step_bytes(esz_i);

    scb_start_sel #(.ADDR_W(ADDR_W)) u_start (
        .scratch_i (scratch_i),
        .circ_i    (circ_i),
        .ofs_i     (ofs_i),
        .base_i    (base_i),
        .size_m1_i (size_m1_i),
        .start_o   (start_w),
        .end_o     (end_w),
        .span_o    (span_w),
        .wrap_o    (wrap_w)
    );

    scb_stepper #(.ADDR_W(ADDR_W)) u_step (
        .addr_i (st_q.addr),
        .step_i (step_w),
        .wrap_i (st_q.wrap),
        .end_i  (st_q.end_a),
        .span_i (st_q.span),
        .nxt_o  (nxt_w)
    );

    always_comb begin
        st_d         = st_q;
        st_d.fin_vld = 1'b0;
        if (ld_i) begin
            st_d.addr  = start_w;
            st_d.base  = base_i;
            st_d.end_a = end_w;
            st_d.span  = span_w;
            st_d.wrap  = wrap_w;
            st_d.wb    = wb_i & scratch_i;
        end else if (adv_i) begin
            st_d.addr = nxt_w;
            if (last_i && st_q.wb) begin
                st_d.fin_vld = 1'b1;
                st_d.fin_ofs = nxt_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o    = st_q.addr;
    assign fin_ofs_o = st_q.fin_ofs;
    assign fin_vld_o = st_q.fin_vld;

    // Linear advance moves by exactly one element.
    assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !ld_i && !st_q.wrap) |=>
            addr_o == ADDR_W'($past(addr_o) + ADDR_W'($past(step_w))));

    // Idle cycles keep the address.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !ld_i) |=> $stable(addr_o));

    // A wrapping transfer stays inside its buffer.
    assert_in_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wrap |-> (addr_o >= st_q.base) && ({1'b0, addr_o} < st_q.end_a));

    // Offset below base is raised to base.
    assert_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && scratch_i && circ_i && (ofs_i < base_i)) |=> addr_o == $past(base_i));

    // Final offset only follows a flagged last advance, and lasts one cycle.
    assert_fin_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fin_vld_o |-> $past(adv_i && last_i && !ld_i));
    assert_fin_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_vld_o && !adv_i) |=> !fin_vld_o);

    // A load suppresses a simultaneous advance.
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && adv_i) |=> !fin_vld_o);
endmodule

// File: tb/sim_scb_addr_gen.sv
module sim_scb_addr_gen;
    localparam int AW = 16;

    typedef struct packed {
        logic        scr;
        logic        circ;
        logic        wb;
        logic [1:0]  esz;
        logic [15:0] ofs;
        logic [15:0] base;
        logic [15:0] sm1;
        logic [7:0]  n;
        logic [15:0] start;
        logic [15:0] fin;
        logic        fvld;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 1'b1, 2'd2, 16'h01F0, 16'h0100, 16'h00FF, 8'd6, 16'h01F0, 16'h0108, 1'b1},
        '{1'b1, 1'b1, 1'b0, 2'd0, 16'h0080, 16'h0100, 16'h00FF, 8'd3, 16'h0100, 16'h0103, 1'b0},
        '{1'b1, 1'b1, 1'b1, 2'd1, 16'h0200, 16'h0100, 16'h00FF, 8'd4, 16'h0200, 16'h0208, 1'b1},
        '{1'b0, 1'b1, 1'b1, 2'd2, 16'h1234, 16'h0100, 16'h00FF, 8'd5, 16'h0000, 16'h0014, 1'b0},
        '{1'b1, 1'b0, 1'b1, 2'd2, 16'h01F8, 16'h0100, 16'h00FF, 8'd4, 16'h01F8, 16'h0208, 1'b1},
        '{1'b1, 1'b1, 1'b1, 2'd2, 16'h01FC, 16'h0100, 16'h00FE, 8'd1, 16'h01FC, 16'h0101, 1'b1},
        '{1'b1, 1'b1, 1'b1, 2'd2, 16'hFFF8, 16'hF000, 16'h0FFF, 8'd3, 16'hFFF8, 16'hF004, 1'b1},
        '{1'b0, 1'b0, 1'b0, 2'd3, 16'h0000, 16'h0000, 16'h0000, 8'd2, 16'h0000, 16'h0008, 1'b0}
    };
    localparam string VTAG [NV] = '{"R2 R6 R9", "R3 R5", "R4 R9", "R7",
                                     "R8", "R6", "R11", "R5 R7"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld = 1'b0, scr = 1'b0, circ = 1'b0, wb = 1'b0;
    logic [AW-1:0] ofs = '0, base = '0, sm1 = '0;
    logic [1:0]    esz = '0;
    logic          adv = 1'b0, last = 1'b0;
    logic [AW-1:0] addr, fin_ofs;
    logic          fin_vld;
    int            n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    scb_addr_gen #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_i(ld), .scratch_i(scr), .circ_i(circ),
        .wb_i(wb), .ofs_i(ofs), .base_i(base), .size_m1_i(sm1), .esz_i(esz),
        .adv_i(adv), .last_i(last), .addr_o(addr), .fin_ofs_o(fin_ofs),
        .fin_vld_o(fin_vld)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        @(negedge clk);
        ld = 1'b1; scr = v.scr; circ = v.circ; wb = v.wb; esz = v.esz;
        ofs = v.ofs; base = v.base; sm1 = v.sm1;
        @(negedge clk);
        ld = 1'b0;
    endtask

    task automatic step(input logic is_last);
        adv = 1'b1; last = is_last;
        @(negedge clk);
        adv = 1'b0; last = 1'b0;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 addr", 32'(addr), 32'h0);
        check("R1 fin_vld", 32'(fin_vld), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            load(VEC[i]);
            check({VTAG[i], " start"}, 32'(addr), 32'(VEC[i].start));
            for (int k = 0; k < int'(VEC[i].n); k++) begin
                step(k == int'(VEC[i].n) - 1);
            end
            check({VTAG[i], " end addr"}, 32'(addr), 32'(VEC[i].fin));
            check({VTAG[i], " fin_vld"}, 32'(fin_vld), 32'(VEC[i].fvld));
            if (VEC[i].fvld) check({VTAG[i], " fin_ofs"}, 32'(fin_ofs), 32'(VEC[i].fin));
            @(negedge clk);
            check({VTAG[i], " R9 pulse ends"}, 32'(fin_vld), 32'h0);
            check({VTAG[i], " R5 hold"}, 32'(addr), 32'(VEC[i].fin));
        end

        // R10: load together with advance; advance is dropped.
        @(negedge clk);
        ld = 1'b1; scr = 1'b1; circ = 1'b1; wb = 1'b1; esz = 2'd2;
        ofs = 16'h0140; base = 16'h0100; sm1 = 16'h00FF;
        adv = 1'b1; last = 1'b1;
        @(negedge clk);
        ld = 1'b0; adv = 1'b0; last = 1'b0;
        check("R10 addr", 32'(addr), 32'h0140);
        check("R10 fin_vld", 32'(fin_vld), 32'h0);

        // R9: advance without last does not report.
        step(1'b0);
        check("R9 no last addr", 32'(addr), 32'h0144);
        check("R9 no last fin_vld", 32'(fin_vld), 32'h0);

        // R6: exact landing on end wraps to base.
        load('{1'b1, 1'b1, 1'b0, 2'd1, 16'h01FE, 16'h0100, 16'h00FF, 8'd1, 16'h01FE, 16'h0100, 1'b0});
        step(1'b1);
        check("R6 exact wrap", 32'(addr), 32'h0100);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule